// File: doc/BRIEF.md
# SPI Boot Handshake Host

This block is the host side of the opening handshake with a peripheral that boots over SPI. After a start pulse it waits until the peripheral raises its service-request interrupt. It then sends a fixed preamble of eight 16-bit words, each in its own chip-select frame. It then watches for the peripheral to drop the request. A dropped request ends the session with `done`. A request that is still held after a programmable number of cycles ends the session with `timeout`.

The SPI link runs with the clock idling low. The host changes data on each rising edge and the peripheral samples on each falling edge. Each word goes out most significant bit first. A half-period divider input sets the SPI clock rate. The block holds at least two SPI periods of chip-select setup before the first clock edge, and at least two SPI periods of chip-select-high time between words. The interrupt input passes through a two-flop synchronizer. By default it is read as active low, and a parameter selects active high.

Top module: `spiboot_host`

## Requirements
- R1: While reset is held and afterwards until a start pulse, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `timeout` are 0.
- R2: After a start pulse, `busy` is 1 and no chip-select frame begins while the interrupt is inactive. With the default polarity, the interrupt is active when `irq_in` is 0.
- R3: Once the interrupt is active, the block sends eight words in this order: 0x5678, 0x8765, then 0xFFFF six times. Each word goes out MSB first.
- R4: Each word gets its own frame, during which `spi_cs_n` stays low. Each frame has exactly 16 rising and 16 falling SCLK edges. `spi_sclk` is never 1 while `spi_cs_n` is 1.
- R5: From `spi_cs_n` falling to the first SCLK rise, at least 4*(div_half+1) system cycles pass, which is two SPI periods.
- R6: Between frames, `spi_cs_n` stays high for at least 4*(div_half+1) system cycles.
- R7: The SPI mode is CPOL 0, CPHA 1. SCLK idles low, and `spi_mosi` changes only in the cycle where SCLK rises, so it is steady at every falling edge.
- R8: Successive SCLK rises within a frame are exactly 2*(div_half+1) system cycles apart.
- R9: After the eighth word, once the interrupt is inactive, `done` goes to 1 and `busy` to 0. `done` stays 0 while the interrupt is still active. If the peripheral releases the interrupt before the preamble ends, the block still sends all eight words and then reports `done`.
- R10: If the interrupt stays active for timeout_lim+1 cycles after the preamble, `timeout` goes to 1, `busy` goes to 0 and `done` stays 0.
- R11: A start pulse while `busy` is 1 has no effect: no extra or repeated words are sent. A start pulse while idle clears `done` and `timeout` and opens a new session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a session when idle |
| div_half | input | DIV_W | SCLK half period in system cycles, minus one |
| timeout_lim | input | TO_W | Cycles allowed for interrupt release, minus one |
| irq_in | input | 1 | Peripheral service-request line, asynchronous |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data from host to peripheral |
| busy | output | 1 | Session in progress |
| done | output | 1 | Handshake completed, held until next start |
| timeout | output | 1 | Release not seen in time, held until next start |

## Verification
The hardest case to reach from the ports is a start pulse arriving in the middle of the preamble. So is a peripheral that drops its request before the preamble has finished. Both need stimulus timed against frames already on the wire. The bench decodes SCLK, CS and MOSI cycle by cycle and counts finished frames. Its tasks release the interrupt, or pulse start, when a chosen frame count is reached, and then check that all eight words still arrive exactly once. The bench also places the timeout window against the last chip-select rise that it measures.

// File: rtl/spiboot_pkg.sv
// Shared constants, state types and the preamble table for the SPI boot host.
// Assumes 16-bit SPI words; the preamble is computed, not stored.
package spiboot_pkg;

    localparam int WORD_W       = 16;
    localparam int PRE_WORDS    = 8;
    localparam int SETUP_HALVES = 4;   // two SPI periods
    localparam int GAP_HALVES   = 4;   // two SPI periods

    typedef enum logic [2:0] {
        H_IDLE,
        H_WAIT_REQ,
        H_ISSUE,
        H_FRAME,
        H_WAIT_REL
    } host_st_t;

    typedef enum logic [2:0] {
        F_IDLE,
        F_SETUP,
        F_SHIFT,
        F_HOLD,
        F_GAP
    } frame_st_t;

    // Word number idx of the boot preamble: two sync words then filler.
    function automatic logic [WORD_W-1:0] preamble_word(input int idx);
        case (idx)
            0:       preamble_word = 16'h5678;
            1:       preamble_word = 16'h8765;
            default: preamble_word = 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/spiboot_sync.sv
// Two-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level; resets to RST_VAL.
module spiboot_sync #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic meta;

    // Two register stages toward the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/spiboot_clkdiv.sv
// Half-period tick generator for the SPI clock.
// A tick comes every div_half+1 cycles; clr restarts the phase so the
// first tick lands exactly div_half+1 cycles later.
module spiboot_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div_half);

    // Count system cycles within a half period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: with a stable nonzero divider, ticks never come back to back.
    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && div_half != '0 && $stable(div_half)) |=> !tick);

endmodule

// File: rtl/spiboot_frame.sv
// Sends one 16-bit word in its own chip-select frame, CPOL 0 / CPHA 1, MSB first.
// Order of events: CS low, SETUP half periods, 16 clock pulses, one half period
// of hold, CS high, GAP half periods. Then a one-cycle done pulse.
// Assumes go is only raised while the engine is idle.
module spiboot_frame
    import spiboot_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] word,
    input  logic [DIV_W-1:0]  div_half,
    output logic              frame_done,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi
);

    localparam int HCNT_W = $clog2(SETUP_HALVES > GAP_HALVES ? SETUP_HALVES : GAP_HALVES) + 1;
    localparam int BIT_W  = $clog2(WORD_W) + 1;

    frame_st_t         st;
    logic [HCNT_W-1:0] hcnt;
    logic [BIT_W-1:0]  bitn;
    logic [WORD_W-1:0] shreg;
    logic              tick;
    logic              accept;

    assign accept = go && (st == F_IDLE);

    spiboot_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .div_half (div_half),
        .tick     (tick)
    );

    // Frame sequencer: chip select, clock pulses and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= F_IDLE;
            hcnt       <= '0;
            bitn       <= '0;
            shreg      <= '0;
            spi_sclk   <= 1'b0;
            spi_cs_n   <= 1'b1;
            spi_mosi   <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (st)
                F_IDLE: begin
                    if (go) begin
                        shreg    <= word;
                        spi_cs_n <= 1'b0;
                        hcnt     <= '0;
                        bitn     <= '0;
                        st       <= F_SETUP;
                    end
                end
                F_SETUP: begin
                    if (tick) begin
                        if (hcnt == HCNT_W'(SETUP_HALVES - 1)) begin
                            spi_sclk <= 1'b1;
                            spi_mosi <= shreg[WORD_W-1];
                            shreg    <= {shreg[WORD_W-2:0], 1'b0};
                            st       <= F_SHIFT;
                        end else begin
                            hcnt <= hcnt + 1'b1;
                        end
                    end
                end
                F_SHIFT: begin
                    if (tick) begin
                        if (spi_sclk) begin
                            spi_sclk <= 1'b0;
                            bitn     <= bitn + 1'b1;
                            if (bitn == BIT_W'(WORD_W - 1)) begin
                                st <= F_HOLD;
                            end
                        end else begin
                            spi_sclk <= 1'b1;
                            spi_mosi <= shreg[WORD_W-1];
                            shreg    <= {shreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                F_HOLD: begin
                    if (tick) begin
                        spi_cs_n <= 1'b1;
                        hcnt     <= '0;
                        st       <= F_GAP;
                    end
                end
                F_GAP: begin
                    if (tick) begin
                        if (hcnt == HCNT_W'(GAP_HALVES - 1)) begin
                            frame_done <= 1'b1;
                            st         <= F_IDLE;
                        end else begin
                            hcnt <= hcnt + 1'b1;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // Checker state: half periods seen with CS low, with CS high, and falling edges per frame.
    logic [3:0] chk_low_ticks;
    logic [3:0] chk_high_ticks;
    logic [5:0] chk_falls;
    logic       sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_low_ticks  <= '0;
            chk_high_ticks <= 4'd15;
            chk_falls      <= '0;
            sclk_q         <= 1'b0;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_cs_n) begin
                chk_low_ticks <= '0;
                if (tick && chk_high_ticks != 4'd15) chk_high_ticks <= chk_high_ticks + 1'b1;
            end else begin
                chk_high_ticks <= '0;
                if (tick && chk_low_ticks != 4'd15) chk_low_ticks <= chk_low_ticks + 1'b1;
            end
            if (spi_cs_n && !accept) chk_falls <= '0;
            else if (sclk_q && !spi_sclk) chk_falls <= chk_falls + 1'b1;
        end
    end

    // R4: the clock only pulses inside a frame.
    a_r4_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    // R4: a frame closes only after exactly sixteen falling edges.
    a_r4_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (chk_falls == 6'd16));

    // R5: every rising edge is at least two SPI periods after CS fell.
    a_r5_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> (chk_low_ticks >= 4'(SETUP_HALVES)));

    // R6: CS high for at least two SPI periods before the next frame.
    a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (chk_high_ticks >= 4'(GAP_HALVES)));

    // R7: data moves only with a rising clock edge.
    a_r7_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> $rose(spi_sclk));

endmodule

// File: rtl/spiboot_host.sv
// Host controller for the SPI boot handshake. After start it waits for the
// peripheral's request, sends the eight-word preamble one frame per word,
// then waits for the request to drop (done) or for the limit to run out (timeout).
// Assumes irq_in is asynchronous; IRQ_ACT_LOW selects its active level.
module spiboot_host
    import spiboot_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int TO_W        = 16,
    parameter bit IRQ_ACT_LOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_half,
    input  logic [TO_W-1:0]  timeout_lim,
    input  logic             irq_in,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    output logic             busy,
    output logic             done,
    output logic             timeout
);

    localparam int IDX_W = $clog2(PRE_WORDS);

    host_st_t          st;
    logic [IDX_W-1:0]  idx;
    logic [TO_W-1:0]   wcnt;
    logic              go_q;
    logic              frame_done;
    logic              irq_s;
    logic              irq_act;
    logic [WORD_W-1:0] cur_word;

    spiboot_sync #(.RST_VAL(IRQ_ACT_LOW)) u_irq_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (irq_s)
    );

    assign irq_act  = IRQ_ACT_LOW ? !irq_s : irq_s;
    assign cur_word = preamble_word(int'(idx));
    assign busy     = (st != H_IDLE);

    spiboot_frame #(.DIV_W(DIV_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_q),
        .word       (cur_word),
        .div_half   (div_half),
        .frame_done (frame_done),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi)
    );

    // Session sequencer: request wait, word issue, release wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= H_IDLE;
            idx     <= '0;
            wcnt    <= '0;
            go_q    <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (st)
                H_IDLE: begin
                    if (start) begin
                        done    <= 1'b0;
                        timeout <= 1'b0;
                        idx     <= '0;
                        st      <= H_WAIT_REQ;
                    end
                end
                H_WAIT_REQ: begin
                    if (irq_act) st <= H_ISSUE;
                end
                H_ISSUE: begin
                    go_q <= 1'b1;
                    st   <= H_FRAME;
                end
                H_FRAME: begin
                    if (frame_done) begin
                        if (idx == IDX_W'(PRE_WORDS - 1)) begin
                            wcnt <= '0;
                            st   <= H_WAIT_REL;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= H_ISSUE;
                        end
                    end
                end
                H_WAIT_REL: begin
                    if (!irq_act) begin
                        done <= 1'b1;
                        st   <= H_IDLE;
                    end else if (wcnt == timeout_lim) begin
                        timeout <= 1'b1;
                        st      <= H_IDLE;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: st <= H_IDLE;
            endcase
        end
    end

    // R2: no frame while still waiting for the request.
    a_r2_quiet_before_req: assert property (@(posedge clk) disable iff (!rst_n)
        (st == H_WAIT_REQ) |-> spi_cs_n);

    // R9: success is only reported after a cycle with the request inactive.
    a_r9_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!irq_act));

    // R9: done, timeout and busy exclude one another.
    a_r9_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!timeout && !busy));

    // R10: a timed-out session has returned to idle.
    a_r10_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !busy);

endmodule

// File: tb/spiboot_host_tb.sv
// Directed bench for spiboot_host: a pin-level monitor decodes frames,
// one task per scenario checks its own results.
module spiboot_host_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  div_half = 8'd1;
    logic [15:0] timeout_lim = 16'd1000;
    logic        irq_n = 1'b1;
    logic        spi_sclk, spi_cs_n, spi_mosi, busy, done, timeout;

    int checks = 0;
    int failures = 0;
    int tb_cyc = 0;

    always #10 clk = ~clk;

    spiboot_host u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .div_half    (div_half),
        .timeout_lim (timeout_lim),
        .irq_in      (irq_n),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .busy        (busy),
        .done        (done),
        .timeout     (timeout)
    );

    always @(posedge clk) tb_cyc <= tb_cyc + 1;

    // Pin monitor state.
    logic        mon_clr = 1'b0;
    int          frame_cnt, mosi_viol, sclk_viol;
    int          min_setup, min_gap, min_per, max_per;
    logic [15:0] words [0:15];
    int          falls [0:15];
    int          rises [0:15];
    int          mcyc = 0, t_fall = 0, t_rise_cs = 0, t_rise_clk = 0;
    int          nfall = 0, nrise = 0;
    bit          first_clk = 1'b0, have_gap = 1'b0;
    logic [15:0] sh = '0;
    logic        cs_p = 1'b1, sclk_p = 1'b0, mosi_p = 1'b0;

    // Decode frames and timing at every falling clock edge.
    always @(negedge clk) begin
        mcyc++;
        if (mon_clr) begin
            frame_cnt = 0; mosi_viol = 0; sclk_viol = 0;
            min_setup = 99999; min_gap = 99999; min_per = 99999; max_per = 0;
            have_gap = 1'b0;
        end else begin
            if (cs_p && !spi_cs_n) begin
                t_fall = mcyc; nfall = 0; nrise = 0; first_clk = 1'b1; sh = '0;
                if (have_gap && (mcyc - t_rise_cs) < min_gap) min_gap = mcyc - t_rise_cs;
            end
            if (!sclk_p && spi_sclk) begin
                if (first_clk) begin
                    if ((mcyc - t_fall) < min_setup) min_setup = mcyc - t_fall;
                    first_clk = 1'b0;
                end else begin
                    if ((mcyc - t_rise_clk) < min_per) min_per = mcyc - t_rise_clk;
                    if ((mcyc - t_rise_clk) > max_per) max_per = mcyc - t_rise_clk;
                end
                t_rise_clk = mcyc;
                nrise++;
            end
            if (sclk_p && !spi_sclk) begin
                sh = {sh[14:0], spi_mosi};
                nfall++;
            end
            if ((spi_mosi !== mosi_p) && !(!sclk_p && spi_sclk)) mosi_viol++;
            if (spi_sclk && spi_cs_n) sclk_viol++;
            if (!cs_p && spi_cs_n) begin
                if (frame_cnt < 16) begin
                    words[frame_cnt] = sh;
                    falls[frame_cnt] = nfall;
                    rises[frame_cnt] = nrise;
                end
                frame_cnt++;
                t_rise_cs = mcyc;
                have_gap = 1'b1;
            end
        end
        cs_p = spi_cs_n; sclk_p = spi_sclk; mosi_p = spi_mosi;
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        step(2);
        mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 60000 && frame_cnt < n; i++) step(1);
    endtask

    function automatic logic [15:0] exp_word(input int i);
        if (i == 0) return 16'h5678;
        if (i == 1) return 16'h8765;
        return 16'hFFFF;
    endfunction

    // Words, bit counts and timing of the last eight frames seen.
    task automatic check_preamble(input int base, input int div);
        for (int i = 0; i < 8; i++) begin
            chk(words[base+i] == exp_word(i), "R3", "preamble word", int'(words[base+i]), int'(exp_word(i)));
            chk(falls[base+i] == 16 && rises[base+i] == 16, "R4", "edges per frame",
                falls[base+i] * 256 + rises[base+i], 16 * 256 + 16);
        end
        chk(min_setup >= 4 * (div + 1), "R5", "cs setup cycles", min_setup, 4 * (div + 1));
        chk(min_gap >= 4 * (div + 1), "R6", "cs gap cycles", min_gap, 4 * (div + 1));
        chk(mosi_viol == 0, "R7", "mosi changes off rising edge", mosi_viol, 0);
        chk(sclk_viol == 0, "R4", "sclk high with cs high", sclk_viol, 0);
        chk(min_per == 2 * (div + 1) && max_per == 2 * (div + 1), "R8", "sclk period",
            max_per * 256 + min_per, 2 * (div + 1) * 257);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "pins in reset", {spi_cs_n, spi_sclk}, 2'b10);
        chk(!busy && !done && !timeout, "R1", "status in reset", {busy, done, timeout}, 0);
        rst_n = 1'b1;
        clear_mon();
        step(5);
        chk(spi_cs_n == 1'b1 && !busy && !done && !timeout, "R1", "idle after reset",
            {spi_cs_n, busy, done, timeout}, 4'b1000);
    endtask

    task automatic t_handshake(input int div);
        div_half = 8'(div);
        timeout_lim = 16'd5000;
        irq_n = 1'b1;
        clear_mon();
        pulse_start();
        step(150);
        chk(frame_cnt == 0 && spi_cs_n, "R2", "frames before request", frame_cnt, 0);
        chk(busy == 1'b1, "R2", "busy while waiting", busy, 1);
        irq_n = 1'b0;
        wait_frames(8);
        step(30);
        chk(busy && !done, "R9", "no done while request held", {busy, done}, 2'b10);
        check_preamble(0, div);
        irq_n = 1'b1;
        step(10);
        chk(done && !busy && !timeout, "R9", "done after release", {done, busy, timeout}, 3'b100);
    endtask

    task automatic t_early_release();
        div_half = 8'd1;
        irq_n = 1'b0;
        clear_mon();
        pulse_start();
        wait_frames(2);
        irq_n = 1'b1;
        wait_frames(4);
        step(1);
        chk(busy && !done, "R9", "early release not done mid preamble", {busy, done}, 2'b10);
        wait_frames(8);
        step(30);
        chk(done && !busy, "R9", "done after early release", {done, busy}, 2'b10);
        chk(frame_cnt == 8, "R9", "all words sent on early release", frame_cnt, 8);
        check_preamble(0, 1);
    endtask

    task automatic t_timeout();
        div_half = 8'd0;
        timeout_lim = 16'd50;
        irq_n = 1'b0;
        clear_mon();
        pulse_start();
        wait_frames(8);
        step(49);
        chk(!timeout && busy, "R10", "no timeout before limit", {timeout, busy}, 2'b01);
        step(20);
        chk(timeout && !busy && !done, "R10", "timeout after limit", {timeout, busy, done}, 3'b100);
        check_preamble(0, 0);
        irq_n = 1'b1;
        step(5);
        pulse_start();
        step(1);
        chk(!timeout && busy, "R11", "start clears timeout", {timeout, busy}, 2'b01);
        irq_n = 1'b0;
        wait_frames(16);
        irq_n = 1'b1;
        step(20);
        chk(done && !timeout, "R11", "new session completes", {done, timeout}, 2'b10);
    endtask

    task automatic t_start_busy();
        div_half = 8'd2;
        timeout_lim = 16'd5000;
        irq_n = 1'b0;
        clear_mon();
        pulse_start();
        wait_frames(3);
        pulse_start();
        wait_frames(8);
        step(300);
        chk(frame_cnt == 8 && busy, "R11", "start while busy ignored", frame_cnt, 8);
        check_preamble(0, 2);
        irq_n = 1'b1;
        step(10);
        chk(done, "R11", "session finishes after ignored start", done, 1);
        pulse_start();
        step(2);
        chk(!done && busy && frame_cnt == 8, "R11", "start when idle clears done",
            {done, busy}, 2'b01);
        irq_n = 1'b0;
        wait_frames(16);
        irq_n = 1'b1;
        step(20);
        chk(done && frame_cnt == 16, "R11", "second session words", frame_cnt, 16);
    endtask

    initial begin
        t_reset();
        t_handshake(1);
        t_handshake(0);
        t_handshake(3);
        t_early_release();
        t_timeout();
        t_start_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (tb_cyc >= 150000);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", tb_cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule